// File: doc/BRIEF.md
# Static Seven-Segment LCD Drive Generator

This block turns a latched, signed three-and-a-half digit reading into AC waveforms for a static (one common plane) liquid-crystal panel. It takes three BCD digits, a leading-one flag for the half digit, a negative flag and a lamp-test request. From its clock it derives a square-wave common-plane signal. Every segment line is then driven either equal to that plane signal, which leaves the segment dark, or as its complement, which lights it. As a result, the average voltage across each segment is zero.

The half digit only ever shows a "1", so its two segments share one drive line. The sign has its own line. Inputs are sampled only on the clock edge where the plane signal flips, and the segment lines change only on that edge. Upstream logic can therefore update the reading at any time without causing glitches on the glass. Lamp test lights every segment and the minus sign. It does this by freezing the lines at a constant level, which puts a deliberate DC level on the panel while the request is held.

Top module: `lcd_static_driver`

## Requirements
- R1: After reset, `bp_o` starts low and toggles once every HALF_DIV clocks (400 by default), which gives a 50% duty square wave with a period of 2*HALF_DIV clocks (800).
- R2: While reset is asserted and until the first `bp_o` toggle, `bp_o` and every segment, one and minus output are 0.
- R3: In normal operation, a dark segment line equals `bp_o` and a lit segment line equals the complement of `bp_o`.
- R4: Each full digit is decoded with bit 0 = a through bit 6 = g. The lit sets are: 0 = 0x3F, 1 = 0x06, 2 = 0x5B, 3 = 0x4F, 4 = 0x66, 5 = 0x6D, 6 = 0x7D, 7 = 0x07, 8 = 0x7F, 9 = 0x6F.
- R5: A BCD code from 10 to 15 blanks its digit, so all seven lines of that digit equal `bp_o`.
- R6: `one_o` is lit exactly when `lead_one_i` was 1 at the last `bp_o` toggle.
- R7: `minus_o` is lit exactly when `neg_i` was 1 at the last `bp_o` toggle.
- R8: Inputs are sampled only on the clock edge where `bp_o` toggles. No output other than `bp_o` changes on any other edge, and input changes between toggles have no visible effect until the next toggle.
- R9: At the first `bp_o` toggle that samples `lamp_test_i` high, all 23 segment, one and minus lines are driven to the complement of the new `bp_o`. At later toggles with `lamp_test_i` still high, those lines keep that level while `bp_o` continues to toggle.
- R10: At the first toggle that samples `lamp_test_i` low after a lamp test, normal drive (R3 to R7) resumes from the inputs sampled on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| digit_units_i | input | 4 | Units BCD digit |
| digit_tens_i | input | 4 | Tens BCD digit |
| digit_hund_i | input | 4 | Hundreds BCD digit |
| lead_one_i | input | 1 | Half digit shows "1" |
| neg_i | input | 1 | Reading is negative |
| lamp_test_i | input | 1 | Light all segments with static levels |
| bp_o | output | 1 | Common-plane square wave |
| seg_units_o | output | 7 | Units segment lines, bit 0 = a to bit 6 = g |
| seg_tens_o | output | 7 | Tens segment lines |
| seg_hund_o | output | 7 | Hundreds segment lines |
| one_o | output | 1 | Shared line for both half-digit segments |
| minus_o | output | 1 | Minus sign line |

## Verification
The plane-signal flip and a change of the reading or of the lamp-test request can fall on the same clock edge. This is where sampling-order mistakes would appear. The bench provokes the overlap by counting cycles from an observed flip and changing the digits and the lamp-test input on the falling edge just before the next flip. It then requires the new values to appear at that flip, as an entry into lamp test or a release from it. Random mid-period input changes are also checked to leave the lines untouched until the following flip.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;

  localparam int unsigned SEG_W   = 7;
  localparam int unsigned BCD_W   = 4;
  localparam int unsigned NUM_DIG = 3;

  typedef logic [SEG_W-1:0] seg7_t;

  // Packed drive word: hundreds, tens, units, half digit, sign.
  typedef struct packed {
    seg7_t hund;
    seg7_t tens;
    seg7_t units;
    logic  one;
    logic  minus;
  } disp_t;

  localparam int unsigned DISP_W = $bits(disp_t);

  // Bit 0 = a ... bit 6 = g; codes above nine are dark.
  function automatic seg7_t bcd_to_seg7(input logic [BCD_W-1:0] code);
    seg7_t s;
    case (code)
      4'd0:    s = 7'h3F;
      4'd1:    s = 7'h06;
      4'd2:    s = 7'h5B;
      4'd3:    s = 7'h4F;
      4'd4:    s = 7'h66;
      4'd5:    s = 7'h6D;
      4'd6:    s = 7'h7D;
      4'd7:    s = 7'h07;
      4'd8:    s = 7'h7F;
      4'd9:    s = 7'h6F;
      default: s = 7'h00;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/lcd_rst_sync.sv
module lcd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/lcd_bp_divider.sv
module lcd_bp_divider #(
  parameter int unsigned HALF_DIV = 400
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic bp_o,
  output logic tick_o
);

  localparam int unsigned CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             bp_q, bp_d;
  logic             wrap;

  assign wrap = (cnt_q == CNT_LAST);

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    bp_d  = bp_q;
    if (wrap) begin
      cnt_d = '0;
      bp_d  = ~bp_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      bp_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      bp_q  <= bp_d;
    end
  end

  assign bp_o   = bp_q;
  assign tick_o = wrap;

  // R1
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_LAST);

  // R1
  bp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o |=> $stable(bp_q));

  // R1
  bp_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (bp_q != $past(bp_q)));

endmodule

// File: rtl/lcd_seg_decoder.sv
module lcd_seg_decoder
  import lcd_drv_pkg::*;
#(
  parameter int unsigned NDIG = NUM_DIG
) (
  input  logic [NDIG-1:0][BCD_W-1:0] bcd_i,
  output seg7_t [NDIG-1:0]           seg_o
);

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    always_comb begin
      seg_o[g] = bcd_to_seg7(bcd_i[g]);
    end
  end

endmodule

// File: rtl/lcd_drive_stage.sv
module lcd_drive_stage
  import lcd_drv_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  tick_i,
  input  logic  bp_i,
  input  logic  lamp_i,
  input  disp_t pattern_i,
  output disp_t drive_o
);

  disp_t disp_q, disp_d;
  logic  held_q, held_d;
  logic  bp_next;

  // Plane level that holds after the current edge when it is a flip.
  assign bp_next = ~bp_i;

  always_comb begin
    disp_d = disp_q;
    held_d = held_q;
    if (tick_i) begin
      if (lamp_i) begin
        if (!held_q) begin
          disp_d = disp_t'({DISP_W{~bp_next}});
        end
        held_d = 1'b1;
      end else begin
        disp_d = pattern_i ^ disp_t'({DISP_W{bp_next}});
        held_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      disp_q <= '0;
      held_q <= 1'b0;
    end else begin
      disp_q <= disp_d;
      held_q <= held_d;
    end
  end

  assign drive_o = disp_q;

  // R8
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(disp_q));

  // R3
  normal_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !lamp_i) |=> ((disp_q ^ disp_t'({DISP_W{bp_i}})) == $past(pattern_i)));

  // R9
  lamp_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && lamp_i && !held_q) |=> (disp_q == disp_t'({DISP_W{~bp_i}})));

  // R9
  lamp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && lamp_i && held_q) |=> $stable(disp_q));

endmodule

// File: rtl/lcd_static_driver.sv
module lcd_static_driver
  import lcd_drv_pkg::*;
#(
  parameter int unsigned HALF_DIV = 400
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BCD_W-1:0] digit_units_i,
  input  logic [BCD_W-1:0] digit_tens_i,
  input  logic [BCD_W-1:0] digit_hund_i,
  input  logic             lead_one_i,
  input  logic             neg_i,
  input  logic             lamp_test_i,
  output logic             bp_o,
  output logic [SEG_W-1:0] seg_units_o,
  output logic [SEG_W-1:0] seg_tens_o,
  output logic [SEG_W-1:0] seg_hund_o,
  output logic             one_o,
  output logic             minus_o
);

  logic                          rst_n;
  logic                          bp;
  logic                          tick;
  logic [NUM_DIG-1:0][BCD_W-1:0] bcd;
  seg7_t [NUM_DIG-1:0]           seg;
  disp_t                         pattern;
  disp_t                         drive;

  lcd_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  lcd_bp_divider #(.HALF_DIV(HALF_DIV)) i_bp_divider (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .bp_o   (bp),
    .tick_o (tick)
  );

  assign bcd = {digit_hund_i, digit_tens_i, digit_units_i};

  lcd_seg_decoder #(.NDIG(NUM_DIG)) i_seg_decoder (
    .bcd_i (bcd),
    .seg_o (seg)
  );

  always_comb begin
    pattern.hund  = seg[2];
    pattern.tens  = seg[1];
    pattern.units = seg[0];
    pattern.one   = lead_one_i;
    pattern.minus = neg_i;
  end

  lcd_drive_stage i_drive_stage (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .tick_i    (tick),
    .bp_i      (bp),
    .lamp_i    (lamp_test_i),
    .pattern_i (pattern),
    .drive_o   (drive)
  );

  assign bp_o        = bp;
  assign seg_units_o = drive.units;
  assign seg_tens_o  = drive.tens;
  assign seg_hund_o  = drive.hund;
  assign one_o       = drive.one;
  assign minus_o     = drive.minus;

  // R2
  reset_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(rst_n) |-> (drive == '0 && !bp));

endmodule

// File: tb/test_lcd_static_driver.sv
module test_lcd_static_driver;

  localparam int unsigned HALF = 400;

  logic       clk;
  logic       rst_n;
  logic [3:0] du, dt, dh;
  logic       lead, neg, lamp;
  logic       bp_o;
  logic [6:0] su, st, sh;
  logic       one_o, minus_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_edge_cyc = 0;
  bit first_edge = 1'b1;
  logic [22:0] exp_disp = '0;
  bit held = 1'b0;

  lcd_static_driver #(.HALF_DIV(HALF)) i_lcd_static_driver (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .digit_units_i (du),
    .digit_tens_i  (dt),
    .digit_hund_i  (dh),
    .lead_one_i    (lead),
    .neg_i         (neg),
    .lamp_test_i   (lamp),
    .bp_o          (bp_o),
    .seg_units_o   (su),
    .seg_tens_o    (st),
    .seg_hund_o    (sh),
    .one_o         (one_o),
    .minus_o       (minus_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [6:0] seg7(input logic [3:0] d);
    case (d)
      4'd0: return 7'b0111111;
      4'd1: return 7'b0000110;
      4'd2: return 7'b1011011;
      4'd3: return 7'b1001111;
      4'd4: return 7'b1100110;
      4'd5: return 7'b1101101;
      4'd6: return 7'b1111101;
      4'd7: return 7'b0000111;
      4'd8: return 7'b1111111;
      4'd9: return 7'b1101111;
      default: return 7'b0000000;
    endcase
  endfunction

  function automatic logic [22:0] lit_set();
    return {seg7(dh), seg7(dt), seg7(du), lead, neg};
  endfunction

  function automatic logic [22:0] observed();
    return {sh, st, su, one_o, minus_o};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  // Waits for the next plane flip, then checks the drive against the model.
  task automatic next_edge();
    logic last;
    string tag;
    bit was_held;
    last = bp_o;
    do @(negedge clk); while (bp_o === last);
    if (!first_edge) check("R1 half period", cyc - last_edge_cyc, HALF);
    else check("R1 first flip rises", {31'd0, bp_o}, 32'd1);
    first_edge = 1'b0;
    last_edge_cyc = cyc;
    was_held = held;
    if (lamp) begin
      if (!held) exp_disp = {23{~bp_o}};
      held = 1'b1;
      tag = "R9 lamp drive";
    end else begin
      exp_disp = lit_set() ^ {23{bp_o}};
      held = 1'b0;
      if (was_held) tag = "R10 release";
      else if (du > 9 || dt > 9 || dh > 9) tag = "R5 blank";
      else tag = "R4 decode";
    end
    check(tag, {9'd0, observed()}, {9'd0, exp_disp});
    if (!lamp) begin
      check("R6 half digit", {31'd0, one_o}, {31'd0, lead ^ bp_o});
      check("R7 minus", {31'd0, minus_o}, {31'd0, neg ^ bp_o});
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic mid_change(input bit lamp_ok);
    du = 4'($urandom_range(0, 15));
    dt = 4'($urandom_range(0, 9));
    dh = 4'($urandom_range(0, 9));
    lead = 1'($urandom);
    neg = 1'($urandom);
    lamp = lamp_ok ? ($urandom_range(0, 4) == 0) : 1'b0;
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    du = 0; dt = 0; dh = 0; lead = 0; neg = 0; lamp = 0;
    wait_neg(5);
    // R2
    check("R2 reset outputs", {8'd0, bp_o, observed()}, 32'd0);
    rst_n = 1'b1;
    wait_neg(20);
    check("R2 dark before first flip", {8'd0, bp_o, observed()}, 32'd0);

    next_edge();

    // R4 sweep of all legal digits
    for (int d = 0; d < 10; d++) begin
      du = 4'(d); dt = 4'(9 - d); dh = 4'((d + 3) % 10);
      lead = d[0]; neg = d[1];
      next_edge();
    end

    // R5 codes above nine
    for (int d = 10; d < 16; d++) begin
      du = 4'(d); dt = 4'(d); dh = 4'(d); lead = 0; neg = 0;
      next_edge();
      check("R3 dark equals plane", {25'd0, su}, {25'd0, {7{bp_o}}});
    end

    // R9 entry and hold, then R10 release
    du = 4'd3; dt = 4'd7; dh = 4'd1; lead = 1; neg = 1; lamp = 1;
    next_edge();
    check("R9 all lit", {9'd0, observed()}, {9'd0, {23{~bp_o}}});
    next_edge();
    next_edge();
    check("R9 held level", {9'd0, observed()}, {9'd0, exp_disp});
    lamp = 0;
    next_edge();

    // Same-edge overlap: inputs change on the falling edge before a flip
    next_edge();
    wait_neg(HALF - 1);
    du = 4'd8; dt = 4'd8; dh = 4'd8; lead = 1; neg = 0; lamp = 1;
    next_edge();
    wait_neg(HALF - 1);
    du = 4'd2; dt = 4'd5; dh = 4'd0; lead = 0; neg = 1; lamp = 0;
    next_edge();
    wait_neg(HALF - 1);
    du = 4'd6; dt = 4'd4; dh = 4'd9; lead = 1; neg = 1;
    next_edge();

    // Random changes placed mid-period
    for (int k = 0; k < 60; k++) begin
      wait_neg($urandom_range(1, 300));
      mid_change(1'b1);
      wait_neg(2);
      // R8
      check("R8 no mid-period change", {9'd0, observed()}, {9'd0, exp_disp});
      next_edge();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule